// File: doc/BRIEF.md
# Register Wakeup Scoreboard

This block keeps one availability bit for every physical register of an out-of-order core. Integer and floating-point registers share one index space: integer register `k` has index `k`, and floating-point register `k` has index `INT_REGS + k`. The rename stage records a producer for a destination register, which clears that register's bit. When an instruction finishes, the completion port broadcasts its destination, which sets the bit again. A newly inserted instruction looks up its two source registers. If both are available, it is reported as directly ready. Otherwise it is parked in a waiting slot until the missing operands are broadcast.

Each waiting slot is a small state machine with three states:

- `SLOT_IDLE`: the slot is free. The transition `alloc` moves it to `SLOT_WAIT`.
- `SLOT_WAIT`: the slot holds two source indices and two ready flags. Each completion that matches a source sets that source's flag. The transition `both_ready` moves it to `SLOT_FIRE`.
- `SLOT_FIRE`: the slot raises its wakeup output for one cycle. The transition `retire` returns it to `SLOT_IDLE`.

Every cycle the block also reports how many waiting operands the current completion satisfied.

Top module: `reg_wakeup_scoreboard`

## Requirements
- R1: After reset every register reads as ready and no slot is occupied.
- R2: The ready lookups are combinational and return the stored bit at the unified index. Floating-point register k uses index INT_REGS+k, and its bit is independent of integer register k.
- R3: A completion sets the register's bit from the next cycle. A lookup of a register that is completing in the same cycle returns ready (bypass).
- R4: A producer record clears the register's bit from the next cycle. A lookup in the same cycle still sees the old value.
- R5: When a producer record and a completion name the same register in the same cycle, the bit is 0 afterwards. A lookup in that cycle still returns ready through the bypass.
- R6: An insert whose two sources are both ready raises `ins_direct` in the same cycle and occupies no slot.
- R7: An insert with a source that is not ready takes the lowest-numbered idle slot, whose flags start from the lookup results. If no slot is idle, `ins_full` is raised and the insert is dropped.
- R8: `wake_count` equals the number of not-yet-ready source operands in `SLOT_WAIT` slots whose index equals the completing register. A slot with both sources on that register contributes 2.
- R9: `slot_wake[i]` is high for exactly one cycle: the cycle after slot i's last flag became set. The slot is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_vld | input | 1 | Record a producer for `prod_idx` |
| prod_idx | input | IW | Unified index of the register made pending |
| done_vld | input | 1 | Completion broadcast valid |
| done_idx | input | IW | Unified index of the completed destination |
| ins_vld | input | 1 | Insert an instruction |
| ins_src0 | input | IW | First source index |
| ins_src1 | input | IW | Second source index |
| src0_rdy | output | 1 | First source available (with bypass) |
| src1_rdy | output | 1 | Second source available (with bypass) |
| ins_direct | output | 1 | Insert forwarded straight to the ready path |
| ins_full | output | 1 | Insert dropped, no idle slot |
| slot_wake | output | SLOTS | Per-slot wakeup pulse |
| wake_count | output | CW | Operands satisfied by this cycle's completion |

## Verification
The assertions run on every cycle and cover three things. They check the bit-update rules (completion sets, producer clears, producer wins on a collision). They check that at most one slot is allocated per insert and that `ins_full` only appears when every slot is busy. They check that a firing slot was waiting beforehand and is idle afterwards. Only the bench scenarios can show three other things: the bypass values seen by a lookup, the exact counts of woken operands when several slots share a register, and the lowest-slot allocation order visible through which `slot_wake` bits pulse.

// File: rtl/rwsb_pkg.sv
package rwsb_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_FIRE = 2'd2
    } slot_state_e;
endpackage

// File: rtl/rwsb_bits.sv
module rwsb_bits #(
    parameter int NREGS = 32,
    parameter int IW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prod_vld,
    input  logic [IW-1:0] prod_idx,
    input  logic          done_vld,
    input  logic [IW-1:0] done_idx,
    input  logic [IW-1:0] look0_idx,
    input  logic [IW-1:0] look1_idx,
    output logic          look0_rdy,
    output logic          look1_rdy
);
    logic [NREGS-1:0] avail_q;

    // Later nonblocking write wins: a producer record overrides a completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail_q <= '1;
        end else begin
            if (done_vld) avail_q[done_idx] <= 1'b1;
            if (prod_vld) avail_q[prod_idx] <= 1'b0;
        end
    end

    always_comb begin
        look0_rdy = avail_q[look0_idx] | (done_vld && (done_idx == look0_idx));
        look1_rdy = avail_q[look1_idx] | (done_vld && (done_idx == look1_idx));
    end

    assert_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && !(prod_vld && prod_idx == done_idx)) |=> avail_q[$past(done_idx)]);

    assert_prod_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prod_vld |=> !avail_q[$past(prod_idx)]);

    assert_prod_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_vld && done_vld && prod_idx == done_idx) |=> !avail_q[$past(done_idx)]);
endmodule

// File: rtl/rwsb_slot.sv
module rwsb_slot
    import rwsb_pkg::*;
#(
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [IW-1:0] src0,
    input  logic [IW-1:0] src1,
    input  logic          rdy0,
    input  logic          rdy1,
    input  logic          done_vld,
    input  logic [IW-1:0] done_idx,
    output logic          busy,
    output logic          wake,
    output logic [1:0]    hits
);
    slot_state_e   st_q, st_d;
    logic [IW-1:0] s0_q, s1_q;
    logic          f0_q, f1_q, f0_d, f1_d;
    logic          m0, m1;

    always_comb begin
        m0 = (st_q == SLOT_WAIT) && done_vld && !f0_q && (s0_q == done_idx);
        m1 = (st_q == SLOT_WAIT) && done_vld && !f1_q && (s1_q == done_idx);
        f0_d = f0_q | m0;
        f1_d = f1_q | m1;
        st_d = st_q;
        unique case (st_q)
            SLOT_IDLE: if (alloc)         st_d = SLOT_WAIT;   // alloc
            SLOT_WAIT: if (f0_d && f1_d)  st_d = SLOT_FIRE;   // both_ready
            SLOT_FIRE:                    st_d = SLOT_IDLE;   // retire
            default:                      st_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SLOT_IDLE;
            s0_q <= '0;
            s1_q <= '0;
            f0_q <= 1'b0;
            f1_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == SLOT_IDLE && alloc) begin
                s0_q <= src0;
                s1_q <= src1;
                f0_q <= rdy0;
                f1_q <= rdy1;
            end else begin
                f0_q <= f0_d;
                f1_q <= f1_d;
            end
        end
    end

    always_comb begin
        busy = (st_q != SLOT_IDLE);
        wake = (st_q == SLOT_FIRE);
        hits = {1'b0, m0} + {1'b0, m1};
    end

    assert_fire_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake && !busy);

    assert_fire_after_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(st_q == SLOT_WAIT));
endmodule

// File: rtl/reg_wakeup_scoreboard.sv
module reg_wakeup_scoreboard #(
    parameter int INT_REGS = 16,
    parameter int FP_REGS  = 16,
    parameter int SLOTS    = 4,
    localparam int NREGS   = INT_REGS + FP_REGS,
    localparam int IW      = $clog2(NREGS),
    localparam int CW      = $clog2(2 * SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prod_vld,
    input  logic [IW-1:0]    prod_idx,
    input  logic             done_vld,
    input  logic [IW-1:0]    done_idx,
    input  logic             ins_vld,
    input  logic [IW-1:0]    ins_src0,
    input  logic [IW-1:0]    ins_src1,
    output logic             src0_rdy,
    output logic             src1_rdy,
    output logic             ins_direct,
    output logic             ins_full,
    output logic [SLOTS-1:0] slot_wake,
    output logic [CW-1:0]    wake_count
);
    logic [SLOTS-1:0] busy, alloc;
    logic [1:0]       hits [SLOTS];
    logic             need_slot;

    rwsb_bits #(.NREGS(NREGS), .IW(IW)) u_bits (
        .clk(clk), .rst_n(rst_n),
        .prod_vld(prod_vld), .prod_idx(prod_idx),
        .done_vld(done_vld), .done_idx(done_idx),
        .look0_idx(ins_src0), .look1_idx(ins_src1),
        .look0_rdy(src0_rdy), .look1_rdy(src1_rdy)
    );

    always_comb begin
        ins_direct = ins_vld && src0_rdy && src1_rdy;
        need_slot  = ins_vld && !(src0_rdy && src1_rdy);
        alloc      = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                alloc    = '0;
                alloc[i] = need_slot;
            end
        end
        ins_full = need_slot && (&busy);
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        rwsb_slot #(.IW(IW)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc(alloc[g]),
            .src0(ins_src0), .src1(ins_src1),
            .rdy0(src0_rdy), .rdy1(src1_rdy),
            .done_vld(done_vld), .done_idx(done_idx),
            .busy(busy[g]), .wake(slot_wake[g]), .hits(hits[g])
        );
    end

    always_comb begin
        wake_count = '0;
        for (int i = 0; i < SLOTS; i++) wake_count = wake_count + CW'(hits[i]);
    end

    assert_one_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc));

    assert_full_only_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ins_full |-> ($countones(busy) == SLOTS));

    assert_alloc_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|alloc) |=> ((busy & $past(alloc)) == $past(alloc)));
endmodule

// File: tb/tb_reg_wakeup_scoreboard.sv
module tb_reg_wakeup_scoreboard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prod_vld = 0, done_vld = 0, ins_vld = 0;
    logic [4:0] prod_idx = 0, done_idx = 0, ins_src0 = 0, ins_src1 = 0;
    logic       src0_rdy, src1_rdy, ins_direct, ins_full;
    logic [3:0] slot_wake;
    logic [3:0] wake_count;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    reg_wakeup_scoreboard dut (
        .clk(clk), .rst_n(rst_n),
        .prod_vld(prod_vld), .prod_idx(prod_idx),
        .done_vld(done_vld), .done_idx(done_idx),
        .ins_vld(ins_vld), .ins_src0(ins_src0), .ins_src1(ins_src1),
        .src0_rdy(src0_rdy), .src1_rdy(src1_rdy),
        .ins_direct(ins_direct), .ins_full(ins_full),
        .slot_wake(slot_wake), .wake_count(wake_count)
    );

    typedef struct packed {
        logic       pv; logic [4:0] pi;
        logic       dv; logic [4:0] di;
        logic [4:0] s0; logic [4:0] s1;
        logic       e0; logic       e1;
    } vec_t;

    // Lookup-only rows: each applied for one cycle, outputs checked before the edge.
    localparam vec_t TBL [12] = '{
        '{1'b0, 5'd0,  1'b0, 5'd0,  5'd3,  5'd20, 1'b1, 1'b1},  // R1 reset state
        '{1'b1, 5'd3,  1'b0, 5'd0,  5'd3,  5'd20, 1'b1, 1'b1},  // R4 old value same cycle
        '{1'b1, 5'd20, 1'b0, 5'd0,  5'd3,  5'd20, 1'b0, 1'b1},  // R4 cleared
        '{1'b0, 5'd0,  1'b0, 5'd0,  5'd3,  5'd20, 1'b0, 1'b0},  // R4
        '{1'b0, 5'd0,  1'b1, 5'd3,  5'd3,  5'd20, 1'b1, 1'b0},  // R3 bypass
        '{1'b0, 5'd0,  1'b0, 5'd0,  5'd3,  5'd20, 1'b1, 1'b0},  // R3 stored
        '{1'b1, 5'd20, 1'b1, 5'd20, 5'd20, 5'd3,  1'b1, 1'b1},  // R5 bypass on collision
        '{1'b0, 5'd0,  1'b0, 5'd0,  5'd20, 5'd3,  1'b0, 1'b1},  // R5 producer wins
        '{1'b1, 5'd21, 1'b0, 5'd0,  5'd21, 5'd5,  1'b1, 1'b1},  // R2 fp reg 5 = index 21
        '{1'b0, 5'd0,  1'b0, 5'd0,  5'd21, 5'd5,  1'b0, 1'b1},  // R2 int 5 untouched
        '{1'b0, 5'd0,  1'b1, 5'd21, 5'd21, 5'd20, 1'b1, 1'b0},  // R3 fp completion
        '{1'b0, 5'd0,  1'b0, 5'd0,  5'd21, 5'd20, 1'b1, 1'b0}   // R2 R3
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        prod_vld = 0; done_vld = 0; ins_vld = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1: no slot busy, nothing woken
        chk("R1 slot_wake", int'(slot_wake), 0);
        chk("R1 wake_count", int'(wake_count), 0);

        foreach (TBL[i]) begin
            prod_vld = TBL[i].pv; prod_idx = TBL[i].pi;
            done_vld = TBL[i].dv; done_idx = TBL[i].di;
            ins_src0 = TBL[i].s0; ins_src1 = TBL[i].s1;
            #1;
            chk($sformatf("R2 R3 R4 R5 row%0d src0", i), int'(src0_rdy), int'(TBL[i].e0));
            chk($sformatf("R2 R3 R4 R5 row%0d src1", i), int'(src1_rdy), int'(TBL[i].e1));
            step();
        end
        idle_in();
        // Pending now: 20 only.

        // R6 direct forward
        ins_vld = 1; ins_src0 = 5; ins_src1 = 6; #1;
        chk("R6 direct", int'(ins_direct), 1);
        chk("R6 not full", int'(ins_full), 0);
        step(); idle_in();
        done_vld = 1; done_idx = 5; #1;
        chk("R6 no slot holds it", int'(wake_count), 0);
        step(); idle_in();
        chk("R6 no wake", int'(slot_wake), 0);

        // R7/R8/R9 two slots
        prod_vld = 1; prod_idx = 7; step();
        prod_idx = 8; step(); idle_in();
        ins_vld = 1; ins_src0 = 7; ins_src1 = 8; #1;
        chk("R7 not direct", int'(ins_direct), 0);
        step();
        ins_src0 = 8; ins_src1 = 9; step(); idle_in();
        done_vld = 1; done_idx = 7; #1;
        chk("R8 one operand", int'(wake_count), 1);
        step(); idle_in();
        chk("R9 no early wake", int'(slot_wake), 0);
        done_vld = 1; done_idx = 8; #1;
        chk("R8 two slots", int'(wake_count), 2);
        step(); idle_in();
        chk("R9 wake slots 0,1", int'(slot_wake), 3);
        step();
        chk("R9 single pulse", int'(slot_wake), 0);

        // R7 fill all slots, fifth dropped
        prod_vld = 1; prod_idx = 10; step(); idle_in();
        for (int k = 0; k < 4; k++) begin
            ins_vld = 1; ins_src0 = 10; ins_src1 = 10; #1;
            chk("R7 slot available", int'(ins_full), 0);
            step();
        end
        #1;
        chk("R7 full", int'(ins_full), 1);
        step(); idle_in();
        done_vld = 1; done_idx = 10; #1;
        chk("R8 both sources each slot", int'(wake_count), 8);
        step(); idle_in();
        chk("R9 all slots wake", int'(slot_wake), 15);
        chk("R7 dropped insert left no slot", int'(wake_count), 0);
        step();
        chk("R9 all idle", int'(slot_wake), 0);

        // R7 lowest slot with partial readiness; R3 bypass at insert
        prod_vld = 1; prod_idx = 11; step(); idle_in();
        ins_vld = 1; ins_src0 = 11; ins_src1 = 12; done_vld = 1; done_idx = 11; #1;
        chk("R3 bypass direct", int'(ins_direct), 1);
        step(); idle_in();
        prod_vld = 1; prod_idx = 13; step(); idle_in();
        ins_vld = 1; ins_src0 = 12; ins_src1 = 13; step(); idle_in();
        done_vld = 1; done_idx = 13; #1;
        chk("R8 ready flag not counted", int'(wake_count), 1);
        step(); idle_in();
        chk("R7 lowest slot 0", int'(slot_wake), 1);

        // R1 reset again restores all bits
        prod_vld = 1; prod_idx = 30; step(); idle_in();
        rst_n = 0; step(); rst_n = 1;
        ins_src0 = 30; ins_src1 = 20; #1;
        chk("R1 after reset src0", int'(src0_rdy), 1);
        chk("R1 after reset src1", int'(src1_rdy), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule